// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block folds a wide vector of level-sensitive interrupt sources into a small number of upstream request lines. The sources are cut into groups of eight. Each group has its own slice of one shared enable word, and each group drives its own upstream output. A group's output is high while at least one of its enabled sources is high. It drops as soon as every such source has gone low or has been disabled.

Software reaches the block over a plain register bus with an address, write data, a write strobe, a read strobe and read data. Enables never take a full-word write. One offset turns on every bit that is written as 1. Another offset turns off every bit that is written as 1. A third offset returns the raw levels of all sources. A sideband port takes a group number and returns the position, within that group, of the lowest-numbered source that is both high and enabled, together with a flag that says whether any such source exists.

Top module: `src_merge_ctl`

## Requirements
- R1: Synchronous active-high reset clears every enable bit. While reset is held and in the cycle after it, all group outputs are 0, `sel_valid_o` is 0, and a read of offset 0x0 returns 0.
- R2: A write to byte offset 0x0 sets each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value. The change is visible from the next clock edge.
- R3: A write to byte offset 0x4 clears each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: A read strobe at offset 0x0 or 0x4 returns the current enable word on `bus_rdata` in the cycle after the strobe. In any cycle that does not follow a read strobe, `bus_rdata` is 0.
- R5: A read of offset 0xC returns the raw source levels, whatever the enables hold.
- R6: Reads of any other offset (for example 0x8 or 0xF) return 0. Writes to those offsets leave the enable word unchanged.
- R7: Group g covers source bits [8g+7:8g]. `grp_irq_o[g]` is 1 exactly when (sources AND enables) is nonzero within those bits. It follows the source levels in the same cycle, with no latching.
- R8: For the group given on `sel_grp_i`, `sel_idx_o` is the index (0 to 7) of the lowest-numbered bit inside that group that is both high and enabled. `sel_valid_o` equals that group's output.
- R9: When the selected group has no high and enabled source, `sel_valid_o` is 0 and `sel_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered one cycle after the read strobe |
| sel_grp_i | input | 2 | Group to query on the sideband |
| grp_irq_o | output | 4 | One upstream request per group |
| sel_idx_o | output | 3 | Lowest pending enabled source within the selected group |
| sel_valid_o | output | 1 | Selected group has a pending enabled source |

## Verification
The bench uses the default build: four groups of eight sources and a 4-bit address. With that build, every 8-bit pattern of a group is reachable in a single sweep. The sweep is run for every group as the selected one, and other patterns are placed in the neighbouring groups at the same time. Find-first-set therefore meets all 256 inputs in every group, and group isolation is tested against live traffic. The sweep runs twice, once with every source enabled and once under a scattered enable word, so that masking by the enables is covered as well as raw level detection.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int GRP_W = 8;
    localparam int IDX_W = $clog2(GRP_W);

    // Byte offsets on the register bus
    localparam int OFF_EN_SET = 'h0;
    localparam int OFF_EN_CLR = 'h4;
    localparam int OFF_STATUS = 'hC;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } grp_pick_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SET,
        ACC_CLR
    } en_op_e;

    // Lowest-numbered set bit of one group slice
    function automatic grp_pick_t lowest_set(input logic [GRP_W-1:0] v);
        grp_pick_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int i = GRP_W - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = IDX_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/smc_enable_bank.sv
module smc_enable_bank
    import smc_pkg::*;
#(
    parameter int SRC_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SRC_W-1:0]  wdata,
    output logic [SRC_W-1:0]  en_o
);

    en_op_e           op;
    logic [SRC_W-1:0] en_q;

    always_comb begin
        op = ACC_NONE;
        if (wr) begin
            if (addr == ADDR_W'(OFF_EN_SET))      op = ACC_SET;
            else if (addr == ADDR_W'(OFF_EN_CLR)) op = ACC_CLR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            case (op)
                ACC_SET: en_q <= en_q | wdata;
                ACC_CLR: en_q <= en_q & ~wdata;
                default: en_q <= en_q;
            endcase
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/smc_group_eval.sv
module smc_group_eval
    import smc_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    localparam int SRC_W     = NUM_GROUPS * GRP_W
) (
    input  logic [SRC_W-1:0]                 src,
    input  logic [SRC_W-1:0]                 en,
    output logic [NUM_GROUPS-1:0]            irq,
    output grp_pick_t [NUM_GROUPS-1:0]       picks
);

    logic [SRC_W-1:0] live;
    assign live = src & en;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [GRP_W-1:0] slice;
        assign slice    = live[g*GRP_W +: GRP_W];
        assign irq[g]   = |slice;
        assign picks[g] = lowest_set(slice);
    end

endmodule

// File: rtl/smc_read_port.sv
module smc_read_port
    import smc_pkg::*;
#(
    parameter int SRC_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SRC_W-1:0]  en,
    input  logic [SRC_W-1:0]  src,
    output logic [SRC_W-1:0]  rdata
);

    logic [SRC_W-1:0] rmux;

    always_comb begin
        rmux = '0;
        if (rd) begin
            if (addr == ADDR_W'(OFF_EN_SET) || addr == ADDR_W'(OFF_EN_CLR))
                rmux = en;
            else if (addr == ADDR_W'(OFF_STATUS))
                rmux = src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rmux;
    end

endmodule

// File: rtl/src_merge_ctl.sv
module src_merge_ctl
    import smc_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = 4,
    localparam int SRC_W     = NUM_GROUPS * GRP_W,
    localparam int SEL_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SRC_W-1:0]      src_i,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [SRC_W-1:0]      bus_wdata,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    output logic [SRC_W-1:0]      bus_rdata,
    input  logic [SEL_W-1:0]      sel_grp_i,
    output logic [NUM_GROUPS-1:0] grp_irq_o,
    output logic [IDX_W-1:0]      sel_idx_o,
    output logic                  sel_valid_o
);

    logic [SRC_W-1:0]            en_q;
    grp_pick_t [NUM_GROUPS-1:0]  picks;
    grp_pick_t                   sel_pick;

    smc_enable_bank #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .en_o  (en_q)
    );

    smc_group_eval #(.NUM_GROUPS(NUM_GROUPS)) u_eval (
        .src   (src_i),
        .en    (en_q),
        .irq   (grp_irq_o),
        .picks (picks)
    );

    smc_read_port #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_rport (
        .clk   (clk),
        .rst   (rst),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .en    (en_q),
        .src   (src_i),
        .rdata (bus_rdata)
    );

    always_comb begin
        sel_pick = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (int'(sel_grp_i) == g) sel_pick = picks[g];
        end
    end

    assign sel_valid_o = sel_pick.hit;
    assign sel_idx_o   = sel_pick.idx;

endmodule

// File: rtl/smc_checker.sv
module smc_checker
    import smc_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = 4,
    localparam int SRC_W     = NUM_GROUPS * GRP_W,
    localparam int SEL_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [SRC_W-1:0]      src,
    input logic [SRC_W-1:0]      en,
    input logic                  wr,
    input logic [ADDR_W-1:0]     addr,
    input logic [SRC_W-1:0]      wdata,
    input logic [SEL_W-1:0]      sel,
    input logic [NUM_GROUPS-1:0] irq,
    input logic [IDX_W-1:0]      idx,
    input logic                  valid
);

    logic [SRC_W-1:0] live;
    logic [GRP_W-1:0] sel_slice;
    logic [GRP_W-1:0] below;
    logic             sel_irq;
    logic             wr_set;
    logic             wr_clr;
    logic             wr_other;

    assign live      = src & en;
    assign sel_slice = GRP_W'(live >> (int'(sel) * GRP_W));
    assign below     = (GRP_W'(1) << idx) - GRP_W'(1);
    assign sel_irq   = irq[sel];
    assign wr_set    = wr && addr == ADDR_W'(OFF_EN_SET);
    assign wr_clr    = wr && addr == ADDR_W'(OFF_EN_CLR);
    assign wr_other  = !(wr_set || wr_clr);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en == '0)); // R1
    AST_SET_ONES: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((en & $past(wdata)) == $past(wdata))); // R2
    AST_SET_KEEP: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((en & ~$past(wdata)) == ($past(en) & ~$past(wdata)))); // R2
    AST_CLR_ONES: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((en & $past(wdata)) == '0)); // R3
    AST_CLR_KEEP: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((en & ~$past(wdata)) == ($past(en) & ~$past(wdata)))); // R3
    AST_EN_STABLE: assert property (@(posedge clk) disable iff (rst)
        wr_other |=> $stable(en)); // R6
    AST_QUIET_GROUPS: assert property (@(posedge clk) disable iff (rst)
        (live == '0) |-> (irq == '0)); // R7
    AST_SEL_AGREES: assert property (@(posedge clk) disable iff (rst)
        valid == sel_irq); // R8
    AST_SEL_IS_SET: assert property (@(posedge clk) disable iff (rst)
        valid |-> sel_slice[idx]); // R8
    AST_SEL_LOWEST: assert property (@(posedge clk) disable iff (rst)
        valid |-> ((sel_slice & below) == '0)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (idx == '0)); // R9

endmodule

bind src_merge_ctl smc_checker #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .src   (src_i),
    .en    (en_q),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .sel   (sel_grp_i),
    .irq   (grp_irq_o),
    .idx   (sel_idx_o),
    .valid (sel_valid_o)
);

// File: tb/test_src_merge_ctl.sv
module test_src_merge_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int NG = 4;
    localparam int SW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] src_i = '0;
    logic [3:0]    bus_addr = '0;
    logic [SW-1:0] bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [SW-1:0] bus_rdata;
    logic [1:0]    sel_grp_i = '0;
    logic [NG-1:0] grp_irq_o;
    logic [2:0]    sel_idx_o;
    logic          sel_valid_o;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic [SW-1:0] exp_en = '0;

    src_merge_ctl i_src_merge_ctl (
        .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .sel_grp_i(sel_grp_i), .grp_irq_o(grp_irq_o),
        .sel_idx_o(sel_idx_o), .sel_valid_o(sel_valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
            summary();
        end
    end

    task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [SW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [SW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        #1 d = bus_rdata;
    endtask

    function automatic logic [NG-1:0] exp_irq(input logic [SW-1:0] s, input logic [SW-1:0] e);
        logic [NG-1:0] r = '0;
        for (int g = 0; g < NG; g++)
            for (int b = 0; b < 8; b++)
                if (s[g*8+b] && e[g*8+b]) r[g] = 1'b1;
        return r;
    endfunction

    // returns {valid, idx}
    function automatic logic [3:0] exp_pick(input logic [SW-1:0] s, input logic [SW-1:0] e, input int g);
        for (int b = 0; b < 8; b++)
            if (s[g*8+b] && e[g*8+b]) return {1'b1, 3'(b)};
        return 4'b0000;
    endfunction

    task automatic sweep(input string tag);
        for (int g = 0; g < NG; g++) begin
            for (int p = 0; p < 256; p++) begin
                logic [7:0] pb;
                logic [SW-1:0] s;
                pb = 8'(p);
                s  = {pb ^ 8'h5A, pb + 8'd3, ~pb, pb};
                // rotate so the swept pattern lands in group g
                s  = (s << (g*8)) | (s >> (SW - g*8));
                if (g == 0) s = {pb ^ 8'h5A, pb + 8'd3, ~pb, pb};
                @(negedge clk);
                src_i = s; sel_grp_i = 2'(g);
                #1;
                chk({tag, " R7 group outputs"}, SW'(grp_irq_o), SW'(exp_irq(s, exp_en)));
                chk({tag, " R8/R9 sideband"}, SW'({sel_valid_o, sel_idx_o}), SW'(exp_pick(s, exp_en, g)));
            end
        end
    endtask

    initial begin
        logic [SW-1:0] d;
        repeat (3) @(negedge clk);
        src_i = '1;
        #1;
        chk("R1 irq in reset", SW'(grp_irq_o), '0);
        chk("R1 valid in reset", SW'(sel_valid_o), '0);
        rst = 1'b0;
        #1;
        chk("R1 irq after reset", SW'(grp_irq_o), '0);
        rd_reg(4'h0, d);
        chk("R1 enable read after reset", d, '0);

        src_i = 32'hDEAD_BEEF;
        rd_reg(4'hC, d);
        chk("R5 raw status with enables off", d, 32'hDEAD_BEEF);

        wr_reg(4'h0, 32'h0000_00F0); exp_en = 32'h0000_00F0;
        rd_reg(4'h0, d);
        chk("R2 set bits", d, exp_en);
        wr_reg(4'h0, 32'h0000_0F00); exp_en = 32'h0000_0FF0;
        rd_reg(4'h0, d);
        chk("R2 zeros keep value", d, exp_en);
        rd_reg(4'h4, d);
        chk("R4 read at clear offset", d, exp_en);

        wr_reg(4'h4, 32'h0000_0030); exp_en = 32'h0000_0FC0;
        rd_reg(4'h0, d);
        chk("R3 clear bits, zeros keep", d, exp_en);

        @(negedge clk); #1;
        chk("R4 rdata zero without strobe", bus_rdata, '0);

        wr_reg(4'h8, 32'hFFFF_FFFF);
        wr_reg(4'hF, 32'hFFFF_FFFF);
        rd_reg(4'h0, d);
        chk("R6 write to other offset ignored", d, exp_en);
        rd_reg(4'h8, d);
        chk("R6 read 0x8", d, '0);
        rd_reg(4'hF, d);
        chk("R6 read 0xF", d, '0);

        wr_reg(4'h0, 32'hFFFF_FFFF); exp_en = '1;
        sweep("all-enabled");

        wr_reg(4'h4, 32'hFFFF_FFFF);
        wr_reg(4'h0, 32'h5AC3_0F81); exp_en = 32'h5AC3_0F81;
        rd_reg(4'h0, d);
        chk("R2 scattered enable", d, exp_en);
        sweep("scattered-enable");

        @(negedge clk);
        src_i = 32'h0000_0100; sel_grp_i = 2'd1;
        #1;
        chk("R7 level high", SW'(grp_irq_o), 32'h2);
        @(negedge clk);
        src_i = '0;
        #1;
        chk("R7 level drop", SW'(grp_irq_o), '0);
        chk("R9 idle sideband", SW'({sel_valid_o, sel_idx_o}), '0);

        summary();
    end

endmodule